// File: doc/BRIEF.md
# Memory-Type Range Register File

This block is a bank of 64-bit configuration registers that describe memory types for physical address ranges. A single request port takes an index, a read/write flag and write data. A capability word is read-only. Eight variable-range entries each have a base register and a mask register. Eleven fixed-range registers cover one 64K region, two 16K regions and eight 4K regions. The bank also holds a page-attribute register and a default-type register.

Every write is checked against the memory-type encodings and reserved bits that apply to the target register. A write that fails these checks is refused: the stored value stays as it was and the response carries a fault. Reads and writes to indices that the map does not contain also fault. The response arrives on the cycle after the request, so the block can sit behind a simple register-access pipeline stage.

Top module: `mtr_regfile`

## Requirements
- R1: Each request cycle (`req_valid` high) produces exactly one response cycle (`rsp_valid` high) on the next clock. There is no response without a request. A read response carries the register value in `rsp_rdata`. A write response and a faulting read response carry zero.
- R2: Index 0x00 is the capability word. It always reads 0x508, and any write to it faults.
- R3: After reset, every register reads zero except the page-attribute register, which reads 0x0007040600070406.
- R4: The legal range memory types are 0 (UC), 1 (WC), 4 (WT), 5 (WP) and 6 (WB). A write to a fixed-range register is accepted only if all eight bytes hold a legal range type. The fixed-range registers are index 0x20 (64K), 0x21 to 0x22 (16K) and 0x28 to 0x2F (4K).
- R5: The page-attribute register at index 0x30 accepts every legal range type and also 7 (UC-), in all eight bytes. Any other byte value faults the write.
- R6: A variable base write is accepted only if bits 11:0, taken as one number, are a legal range type, and bits 63:36 are zero.
- R7: A variable mask write is accepted only if bits 10:0 are zero and bits 63:36 are zero.
- R8: Base and mask registers are interleaved from index 0x10. Index 0x10+2k is the base of entry k and index 0x11+2k is its mask, for k from 0 to 7. Each index holds its own value.
- R9: The default-type register at index 0x31 accepts a write only if byte 0 is a legal range type, bits 63:32 are zero, and bits 31:12 and 9:8 are zero. Bits 11:10 may be set.
- R10: A read or a write to any index outside the map faults.
- R11: A faulting write leaves every stored register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_index | input | 8 | Register index |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_fault | output | 1 | Request refused |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench first reads the whole index range 0x00 to 0x3F after reset. This separates the mapped indices, with their reset values, from the holes that must fault. Fixed-range and page-attribute writes are tried with all-legal byte patterns and with a single bad byte (2, 3, 7 or 8). The value 7 in particular must fault in a fixed-range register and be accepted in the page-attribute register. Base and mask writes probe the type field, the reserved bits and bit 36 one at a time. Distinct values written to all sixteen interleaved indices would expose any swap between base and mask or between entries. Every refused write is followed by a readback of the register it targeted.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  typedef enum logic [2:0] {
    CL_NONE, CL_CAP, CL_VBASE, CL_VMASK, CL_FIX, CL_PAT, CL_DEF
  } mtr_class_e;

  // Index map
  localparam int unsigned IDX_CAP   = 32'h00;
  localparam int unsigned IDX_VAR0  = 32'h10;
  localparam int unsigned IDX_FIX64 = 32'h20;
  localparam int unsigned IDX_FIX16 = 32'h21;
  localparam int unsigned IDX_FIX4  = 32'h28;
  localparam int unsigned IDX_PAT   = 32'h30;
  localparam int unsigned IDX_DEF   = 32'h31;

  localparam logic [63:0] CAP_VALUE = 64'h0000_0000_0000_0508;
  localparam logic [63:0] PAT_RESET = 64'h0007_0406_0007_0406;

  // Memory-type encodings
  localparam logic [7:0] MT_UC  = 8'd0;
  localparam logic [7:0] MT_WC  = 8'd1;
  localparam logic [7:0] MT_WT  = 8'd4;
  localparam logic [7:0] MT_WP  = 8'd5;
  localparam logic [7:0] MT_WB  = 8'd6;
  localparam logic [7:0] MT_UCM = 8'd7;

  function automatic logic range_type_ok(input logic [7:0] t);
    return (t == MT_UC) || (t == MT_WC) || (t == MT_WT) ||
           (t == MT_WP) || (t == MT_WB);
  endfunction

  function automatic logic attr_type_ok(input logic [7:0] t);
    return range_type_ok(t) || (t == MT_UCM);
  endfunction

  // All eight byte lanes must carry a legal type
  function automatic logic lanes_ok(input logic [63:0] w, input logic allow_ucm);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (allow_ucm) ok = ok & attr_type_ok(w[8*b +: 8]);
      else           ok = ok & range_type_ok(w[8*b +: 8]);
    end
    return ok;
  endfunction

endpackage

// File: rtl/mtr_decode.sv
module mtr_decode
  import mtr_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_VAR   = 8,
  parameter int NUM_FIX16 = 2,
  parameter int NUM_FIX4  = 8,
  localparam int NUM_FIX  = 1 + NUM_FIX16 + NUM_FIX4,
  localparam int VOFF_W   = $clog2(2 * NUM_VAR),
  localparam int FSLOT_W  = $clog2(NUM_FIX)
) (
  input  logic [IDX_W-1:0]   index,
  output mtr_class_e         cls,
  output logic [VOFF_W-1:0]  var_off,
  output logic [FSLOT_W-1:0] fix_slot
);

  int unsigned iv;
  assign iv = 32'(index);

  always_comb begin
    cls      = CL_NONE;
    var_off  = '0;
    fix_slot = '0;
    if (iv == IDX_CAP) begin
      cls = CL_CAP;
    end else if (iv >= IDX_VAR0 && iv < IDX_VAR0 + 2 * NUM_VAR) begin
      var_off = VOFF_W'(iv - IDX_VAR0);
      cls     = ((iv - IDX_VAR0) % 2 == 0) ? CL_VBASE : CL_VMASK;
    end else if (iv == IDX_FIX64) begin
      cls = CL_FIX;
    end else if (iv >= IDX_FIX16 && iv < IDX_FIX16 + NUM_FIX16) begin
      cls      = CL_FIX;
      fix_slot = FSLOT_W'(1 + iv - IDX_FIX16);
    end else if (iv >= IDX_FIX4 && iv < IDX_FIX4 + NUM_FIX4) begin
      cls      = CL_FIX;
      fix_slot = FSLOT_W'(1 + NUM_FIX16 + iv - IDX_FIX4);
    end else if (iv == IDX_PAT) begin
      cls = CL_PAT;
    end else if (iv == IDX_DEF) begin
      cls = CL_DEF;
    end
  end

endmodule

// File: rtl/mtr_wcheck.sv
module mtr_wcheck
  import mtr_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  mtr_class_e  cls,
  input  logic [63:0] wdata,
  output logic        legal
);

  logic pa_fits;
  assign pa_fits = ((wdata >> PA_W) == 64'd0);

  always_comb begin
    unique case (cls)
      CL_VBASE: legal = pa_fits && (wdata[11:8] == 4'd0) && range_type_ok(wdata[7:0]);
      CL_VMASK: legal = pa_fits && (wdata[10:0] == 11'd0);
      CL_FIX:   legal = lanes_ok(wdata, 1'b0);
      CL_PAT:   legal = lanes_ok(wdata, 1'b1);
      CL_DEF:   legal = range_type_ok(wdata[7:0]) && (wdata[63:32] == 32'd0) &&
                        ((wdata[31:0] & 32'hFFFF_F300) == 32'd0);
      default:  legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/mtr_regfile.sv
module mtr_regfile
  import mtr_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int PA_W      = 36,
  parameter int NUM_VAR   = 8,
  parameter int NUM_FIX16 = 2,
  parameter int NUM_FIX4  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic [63:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [63:0]      rsp_rdata
);

  localparam int NUM_VREG = 2 * NUM_VAR;
  localparam int NUM_FIX  = 1 + NUM_FIX16 + NUM_FIX4;
  localparam int VOFF_W   = $clog2(NUM_VREG);
  localparam int FSLOT_W  = $clog2(NUM_FIX);

  mtr_class_e         cls;
  logic [VOFF_W-1:0]  var_off;
  logic [FSLOT_W-1:0] fix_slot;
  logic               wr_legal;

  mtr_decode #(
    .IDX_W(IDX_W), .NUM_VAR(NUM_VAR), .NUM_FIX16(NUM_FIX16), .NUM_FIX4(NUM_FIX4)
  ) u_decode (
    .index(req_index), .cls(cls), .var_off(var_off), .fix_slot(fix_slot)
  );

  mtr_wcheck #(.PA_W(PA_W)) u_wcheck (
    .cls(cls), .wdata(req_wdata), .legal(wr_legal)
  );

  // Named internal events
  logic wr_fire, wr_accept, wr_reject, rd_miss;
  assign wr_fire   = req_valid && req_write;
  assign wr_accept = wr_fire && wr_legal;
  assign wr_reject = wr_fire && !wr_legal;
  assign rd_miss   = req_valid && !req_write && (cls == CL_NONE);

  logic [NUM_VREG-1:0] var_we;
  logic [NUM_FIX-1:0]  fix_we;
  logic                pat_we, def_we;
  logic [63:0]         var_q [NUM_VREG];
  logic [63:0]         fix_q [NUM_FIX];
  logic [63:0]         pat_q, def_q;

  for (genvar v = 0; v < NUM_VREG; v++) begin : g_var
    assign var_we[v] = wr_accept && (cls == CL_VBASE || cls == CL_VMASK) &&
                       (var_off == VOFF_W'(v));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         var_q[v] <= '0;
      else if (var_we[v]) var_q[v] <= req_wdata;
    end
  end

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    assign fix_we[f] = wr_accept && (cls == CL_FIX) && (fix_slot == FSLOT_W'(f));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fix_q[f] <= '0;
      else if (fix_we[f]) fix_q[f] <= req_wdata;
    end
  end

  assign pat_we = wr_accept && (cls == CL_PAT);
  assign def_we = wr_accept && (cls == CL_DEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= PAT_RESET;
      def_q <= '0;
    end else begin
      if (pat_we) pat_q <= req_wdata;
      if (def_we) def_q <= req_wdata;
    end
  end

  // Read mux
  logic [63:0] rd_data;
  always_comb begin
    unique case (cls)
      CL_CAP:             rd_data = CAP_VALUE;
      CL_VBASE, CL_VMASK: rd_data = var_q[var_off];
      CL_FIX:             rd_data = fix_q[fix_slot];
      CL_PAT:             rd_data = pat_q;
      CL_DEF:             rd_data = def_q;
      default:            rd_data = '0;
    endcase
  end

  // Response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= wr_reject || rd_miss;
      rsp_rdata <= (req_valid && !req_write && cls != CL_NONE) ? rd_data : '0;
    end
  end

  // Assertions
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  assert_cap_write_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cls == CL_CAP) |=> rsp_fault);
  assert_var_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(var_we));
  assert_unknown_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cls == CL_NONE) |=> rsp_fault);
  assert_reject_holds_attr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(pat_q) && $stable(def_q)));
  assert_reject_no_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> (var_we == '0 && fix_we == '0 && !pat_we && !def_we));

endmodule

// File: tb/tb_mtr_regfile.sv
module tb_mtr_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_index;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_rdata;

  always #5 clk = ~clk;

  mtr_regfile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Scoreboard
  logic        q_fault [$];
  logic [63:0] q_data  [$];
  logic [7:0]  q_idx   [$];
  string       q_tag   [$];

  // Bench-side register model
  logic [63:0] mdl [256];

  function automatic bit in_map(input int i);
    return i == 0 || (i >= 16 && i <= 31) || (i >= 32 && i <= 34) ||
           (i >= 40 && i <= 47) || i == 48 || i == 49;
  endfunction

  function automatic bit rng_ok(input int t);
    return t == 0 || t == 1 || t == 4 || t == 5 || t == 6;
  endfunction

  function automatic bit wr_ok(input int i, input logic [63:0] d);
    bit ok;
    if (i >= 16 && i <= 31) begin
      if (d[63:36] != 0) return 0;
      if (i % 2 == 0) return rng_ok(int'(d[11:0]));
      return d[10:0] == 0;
    end
    if ((i >= 32 && i <= 34) || (i >= 40 && i <= 47) || i == 48) begin
      ok = 1;
      for (int b = 0; b < 8; b++) begin
        int t = int'((d >> (8 * b)) & 64'hFF);
        if (!(rng_ok(t) || (i == 48 && t == 7))) ok = 0;
      end
      return ok;
    end
    if (i == 49)
      return rng_ok(int'(d[7:0])) && d[63:32] == 0 && d[31:12] == 0 && d[9:8] == 0;
    return 0;
  endfunction

  task automatic do_req(input bit wr, input int i, input logic [63:0] d, input string tag);
    logic f;
    logic [63:0] e;
    if (wr) begin
      f = !wr_ok(i, d);
      e = 64'd0;
      if (!f) mdl[i] = d;
    end else begin
      f = !in_map(i);
      e = f ? 64'd0 : (i == 0 ? 64'h508 : mdl[i]);
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_index = 8'(i);
    req_wdata = d;
    q_fault.push_back(f);
    q_data.push_back(e);
    q_idx.push_back(8'(i));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
    end
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s rsp_valid got %b exp 0", tag, rsp_valid);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_fault.size() == 0) begin
        fails++;
        $display("FAIL R1 response with no request: fault=%b data=%h exp none", rsp_fault, rsp_rdata);
      end else begin
        logic        ef;
        logic [63:0] ed;
        logic [7:0]  ei;
        string       et;
        ef = q_fault.pop_front();
        ed = q_data.pop_front();
        ei = q_idx.pop_front();
        et = q_tag.pop_front();
        if (rsp_fault !== ef || rsp_rdata !== ed) begin
          fails++;
          $display("FAIL %s idx=%h fault got %b exp %b data got %h exp %h",
                   et, ei, rsp_fault, ef, rsp_rdata, ed);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 64'd0;
    mdl[48] = 64'h0007_0406_0007_0406;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_index = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_quiet("R3 reset");

    // R3 / R10: sweep reset contents and holes
    for (int i = 0; i < 64; i++) do_req(0, i, 64'd0, "R3_R10 reset sweep");
    do_req(0, 255, 64'd0, "R10 read hole");
    idle(1);
    @(negedge clk);
    check_quiet("R1 single pulse");

    // R2 capability
    do_req(1, 0, 64'h0, "R2 cap write");
    do_req(0, 0, 64'h0, "R2 cap read");

    // R4 fixed ranges
    do_req(1, 32, 64'h0605_0401_0006_0504, "R4 fix64 legal");
    do_req(0, 32, 64'h0, "R4 fix64 read");
    do_req(1, 32, 64'h0606_0606_0206_0606, "R4 type 2 rejected");
    do_req(1, 34, 64'h0707_0606_0606_0606, "R4 type 7 rejected in fixed");
    do_req(1, 47, 64'h0101_0101_0101_0101, "R4 fix4 last legal");
    do_req(0, 32, 64'h0, "R11 fix64 unchanged");
    do_req(0, 34, 64'h0, "R11 fix16 unchanged");
    do_req(0, 47, 64'h0, "R4 fix4 read");

    // R5 page attributes
    do_req(1, 48, 64'h0700_0607_0504_0107, "R5 UC- accepted");
    do_req(0, 48, 64'h0, "R5 read");
    do_req(1, 48, 64'h0800_0000_0000_0000, "R5 type 8 rejected");
    do_req(1, 48, 64'h0000_0000_0000_0003, "R5 type 3 rejected");
    do_req(0, 48, 64'h0, "R11 pat unchanged");

    // R6 base
    do_req(1, 16, 64'h0000_000F_FFFF_F006, "R6 base legal");
    do_req(1, 16, 64'h0000_0000_0000_0106, "R6 bit 8 rejected");
    do_req(1, 16, 64'h0000_0010_0000_0000, "R6 bit 36 rejected");
    do_req(1, 16, 64'h0000_0000_0000_0002, "R6 type 2 rejected");
    do_req(0, 16, 64'h0, "R11 base unchanged");

    // R7 mask
    do_req(1, 17, 64'h0000_000F_FFFF_F800, "R7 mask legal");
    do_req(1, 17, 64'h0000_000F_FFFF_F801, "R7 bit 0 rejected");
    do_req(1, 17, 64'h0000_0100_0000_0000, "R7 bit 40 rejected");
    do_req(0, 17, 64'h0, "R11 mask unchanged");

    // R8 interleave: distinct legal values in all sixteen
    for (int k = 0; k < 8; k++) begin
      do_req(1, 16 + 2 * k, (64'(k + 1) << 12) | 64'h6, "R8 base write");
      do_req(1, 17 + 2 * k, (64'(k + 9) << 12) | 64'h800, "R8 mask write");
    end
    for (int i = 16; i < 32; i++) do_req(0, i, 64'h0, "R8 readback");

    // R9 default type
    do_req(1, 49, 64'h0000_0000_0000_0C06, "R9 legal with 11:10");
    do_req(0, 49, 64'h0, "R9 read");
    do_req(1, 49, 64'h0000_0000_0000_0106, "R9 bit 8 rejected");
    do_req(1, 49, 64'h0000_0001_0000_0006, "R9 high bit rejected");
    do_req(1, 49, 64'h0000_0000_0000_1006, "R9 bit 12 rejected");
    do_req(1, 49, 64'h0000_0000_0000_0003, "R9 type 3 rejected");
    do_req(0, 49, 64'h0, "R11 default unchanged");

    // R10 unknown writes
    do_req(1, 35, 64'h0, "R10 write hole");
    do_req(1, 200, 64'h6, "R10 write far hole");
    do_req(0, 35, 64'h0, "R10 read hole");

    idle(3);
    checks++;
    if (q_fault.size() != 0) begin
      fails++;
      $display("FAIL R1 outstanding responses got %0d exp 0", q_fault.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule